// File: doc/BRIEF.md
# Wavefront Issue Readiness Checker

This block sits between the instruction buffers of a compute unit and its issue scheduler. On every clock it looks at all wavefront slots of all SIMD units at once and decides, for each slot, whether the oldest instruction not yet dispatched may issue now. For every slot it gives a ready flag and a 3-bit reason code. For a ready slot it also gives the index of the execution resource that must take the instruction. The inputs it uses are the slot's wavefront state, the instruction's class bits, the operand-ready answers of the vector and scalar register scoreboards, the wait-counter status and the arrival status of each barrier.

The checks run in a fixed priority. The barrier check comes before the empty-buffer check, so a barrier that is the last buffered instruction cannot deadlock the wavefront. When the barrier of a waiting slot completes, the block pulses a clear for that barrier id. An end-of-program instruction carries an implicit wait-for-zero: it asks the wavefront to enter the wait state with zero targets and stays not ready until all outstanding counters have drained. The block also keeps one saturating counter per reason code. In every cycle each counter grows by the number of slots that ended with that reason.

Top module: `wave_issue_gate`

## Requirements
- R1: A slot in state wait-count (state code 4) whose wait counters are not met (`wait_met_i` low) reports reason WAIT_CNT (3). This check has the highest priority of all.
- R2: A slot in state barrier (code 5) whose selected barrier has not completed (`bar_done_i[bar_sel]` low) reports BAR_WAIT (4). If that barrier has completed, `bar_clear_o[bar_sel]` pulses one cycle and the checks below continue. Several slots on the same id give a single pulse.
- R3: The barrier check comes before the empty-buffer check. A slot in state barrier with an empty buffer reports BAR_WAIT while its barrier is open and IB_EMPTY (2) once the barrier has completed.
- R4: State codes 1 (stopped), 2 (returning) and 3 (stalled) give reason WF_STOP (1). Codes 0, 6 and 7 mean running.
- R5: A running slot with no undispatched buffered instruction (`ib_has_i` low) reports IB_EMPTY (2).
- R6: For an instruction without the scalar class bit (bit 11), a low `vreg_ok_i` gives VREG_WAIT (5). For every instruction, a low `sreg_ok_i` then gives SREG_WAIT (6). The vector check is made first.
- R7: An end-of-program instruction (class bit 4) that is not the oldest buffer entry reports WAIT_CNT. When it is the oldest, `zero_wait_set_o` pulses for that slot, and the slot reports WAIT_CNT until `wait_drained_i` is high.
- R8: Class bits are: 0 ALU, 1 branch, 2 nop, 3 return, 4 end-of-program, 5 barrier, 6 load, 7 store, 8 atomic, 9 memory sync, 10 flat, 11 scalar, 12 local memory, 13 global memory, 14 kernel-argument segment. A ready slot reports READY (7) with `issue_rdy_o` high. Its resource index is chosen in this order: flat goes to the global memory pipe (NUM_SIMD+1). Local memory goes to the local memory pipe (NUM_SIMD+2). Global memory goes to the scalar memory pipe (NUM_SIMD+3) if scalar and to the global memory pipe otherwise. ALU, branch, return, end-of-program, nop, barrier and kernel-argument loads go to the scalar ALU (NUM_SIMD) if scalar and to the slot's own SIMD index otherwise. Anything else gets NUM_SIMD+4 as the invalid marker. A slot that is not ready reports index 0.
- R9: An instruction with none of class bits 0 to 10 set is never ready. It reports WF_STOP and sets `class_err_o`, which stays high until reset.
- R10: All outputs are registered: a result appears one clock after its inputs. During synchronous active-low reset every output is zero.
- R11: The stall counter for reason r (bits r*CNT_W upward in `stall_cnt_o`) grows each cycle by the number of slots that got reason r. It saturates at all ones.
- R12: The block never produces reason code 0 (ILLEGAL) out of reset, so counter 0 stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wf_state_i | input | 3*NW | Per-slot wavefront state code |
| wait_met_i | input | NW | Wait counters meet their current targets |
| wait_drained_i | input | NW | All outstanding counters are zero |
| bar_sel_i | input | BAR_W*NW | Barrier id the slot belongs to |
| bar_done_i | input | NUM_BAR | Every member of the barrier has arrived |
| ib_has_i | input | NW | Buffer holds an undispatched instruction |
| ib_oldest_i | input | NW | Next instruction is the oldest buffer entry |
| inst_class_i | input | 15*NW | Class bits of the next instruction |
| vreg_ok_i | input | NW | Vector register operands ready |
| sreg_ok_i | input | NW | Scalar register operands ready |
| issue_rdy_o | output | NW | Slot may issue |
| reason_o | output | 3*NW | Per-slot reason code |
| exe_idx_o | output | EXE_W*NW | Target execution resource |
| zero_wait_set_o | output | NW | Request to enter wait state with zero targets |
| bar_clear_o | output | NUM_BAR | Clear pulse per completed barrier |
| class_err_o | output | 1 | Sticky unknown-class error |
| stall_cnt_o | output | 8*CNT_W | Per-reason saturating counters |

## Verification
The assertions assume that the barrier ids fit the barrier count, and that the state, class and flag inputs are sampled at the clock edge and stay stable between edges. The bench drives all inputs at the falling edge, draws ids only from the configured range, and forms class words from a fixed set of instruction kinds. An unknown-class kind is added only in the second half of the sweep, so the sticky error can first be seen low and then seen to rise. The configuration uses narrow counters, so that saturation is reached inside the sweep.

// File: rtl/wfrdy_pkg.sv
// Shared codes for the wavefront issue readiness checker.
// Assumes: 3-bit reason codes; READY is encoded as 7 and ILLEGAL as 0.
package wfrdy_pkg;

    typedef enum logic [2:0] {
        RSN_ILLEGAL  = 3'd0,
        RSN_WF_STOP  = 3'd1,
        RSN_IB_EMPTY = 3'd2,
        RSN_WAIT_CNT = 3'd3,
        RSN_BAR_WAIT = 3'd4,
        RSN_VREG     = 3'd5,
        RSN_SREG     = 3'd6,
        RSN_READY    = 3'd7
    } reason_e;

    localparam int RSN_W   = 3;
    localparam int NUM_RSN = 8;

    // wavefront state codes
    localparam logic [2:0] ST_RUN       = 3'd0;
    localparam logic [2:0] ST_STOPPED   = 3'd1;
    localparam logic [2:0] ST_RETURNING = 3'd2;
    localparam logic [2:0] ST_STALLED   = 3'd3;
    localparam logic [2:0] ST_WAITCNT   = 3'd4;
    localparam logic [2:0] ST_BARRIER   = 3'd5;

    // instruction class bit positions
    localparam int CLS_W     = 15;
    localparam int CB_ALU    = 0;
    localparam int CB_BRANCH = 1;
    localparam int CB_NOP    = 2;
    localparam int CB_RET    = 3;
    localparam int CB_ENDPGM = 4;
    localparam int CB_BAR    = 5;
    localparam int CB_LOAD   = 6;
    localparam int CB_STORE  = 7;
    localparam int CB_ATOMIC = 8;
    localparam int CB_MSYNC  = 9;
    localparam int CB_FLAT   = 10;
    localparam int CB_SCALAR = 11;
    localparam int CB_LMEM   = 12;
    localparam int CB_GMEM   = 13;
    localparam int CB_KARG   = 14;

endpackage

// File: rtl/wfrdy_exe_map.sv
// Execution resource selector for one slot.
// Resource index layout: 0..NUM_SIMD-1 vector ALUs, NUM_SIMD scalar ALU,
// +1 global memory, +2 local memory, +3 scalar memory, +4 invalid marker.
// Assumes the caller only uses the result for a ready instruction.
module wfrdy_exe_map #(
    parameter int NUM_SIMD = 2,
    parameter int SIMD_ID  = 0,
    parameter int EXE_W    = 3
) (
    input  logic             is_flat_i,
    input  logic             is_local_i,
    input  logic             is_global_i,
    input  logic             is_scalar_i,
    input  logic             is_exec_i,
    output logic [EXE_W-1:0] idx_o
);

    localparam logic [EXE_W-1:0] IDX_OWN  = EXE_W'(SIMD_ID);
    localparam logic [EXE_W-1:0] IDX_SALU = EXE_W'(NUM_SIMD);
    localparam logic [EXE_W-1:0] IDX_GMEM = EXE_W'(NUM_SIMD + 1);
    localparam logic [EXE_W-1:0] IDX_LMEM = EXE_W'(NUM_SIMD + 2);
    localparam logic [EXE_W-1:0] IDX_SMEM = EXE_W'(NUM_SIMD + 3);
    localparam logic [EXE_W-1:0] IDX_NONE = EXE_W'(NUM_SIMD + 4);

    // Pick the pipe in the fixed class order: flat, local, global, compute.
    always_comb begin
        if (is_flat_i) begin
            idx_o = IDX_GMEM;
        end else if (is_local_i) begin
            idx_o = IDX_LMEM;
        end else if (is_global_i) begin
            idx_o = is_scalar_i ? IDX_SMEM : IDX_GMEM;
        end else if (is_exec_i) begin
            idx_o = is_scalar_i ? IDX_SALU : IDX_OWN;
        end else begin
            idx_o = IDX_NONE;
        end
    end

endmodule

// File: rtl/wfrdy_slot_eval.sv
// Readiness evaluation of one wavefront slot, purely combinational.
// Applies the not-ready checks in priority order and, for a ready slot,
// selects the execution resource. Assumes bar_sel_i < NUM_BAR.
module wfrdy_slot_eval
    import wfrdy_pkg::*;
#(
    parameter int NUM_SIMD = 2,
    parameter int SIMD_ID  = 0,
    parameter int NUM_BAR  = 4,
    parameter int BAR_W    = 2,
    parameter int EXE_W    = 3
) (
    input  logic [2:0]         state_i,
    input  logic               wait_met_i,
    input  logic               wait_drained_i,
    input  logic [BAR_W-1:0]   bar_sel_i,
    input  logic [NUM_BAR-1:0] bar_done_i,
    input  logic               ib_has_i,
    input  logic               ib_oldest_i,
    input  logic [CLS_W-1:0]   cls_i,
    input  logic               vreg_ok_i,
    input  logic               sreg_ok_i,
    output logic [RSN_W-1:0]   reason_o,
    output logic [EXE_W-1:0]   exe_idx_o,
    output logic               zero_set_o,
    output logic [NUM_BAR-1:0] bar_clr_o,
    output logic               bad_cls_o
);

    reason_e          reason;
    logic             bar_hit;
    logic             known;
    logic             is_scalar;
    logic             is_exec;
    logic             halted;
    logic [EXE_W-1:0] map_idx;

    assign known     = |cls_i[CB_FLAT:CB_ALU];
    assign is_scalar = cls_i[CB_SCALAR];
    assign is_exec   = cls_i[CB_ALU] | cls_i[CB_BRANCH] | cls_i[CB_RET] |
                       cls_i[CB_ENDPGM] | cls_i[CB_NOP] | cls_i[CB_BAR] |
                       (cls_i[CB_KARG] & cls_i[CB_LOAD]);
    assign halted    = (state_i == ST_STOPPED) || (state_i == ST_RETURNING) ||
                       (state_i == ST_STALLED);

    wfrdy_exe_map #(
        .NUM_SIMD (NUM_SIMD),
        .SIMD_ID  (SIMD_ID),
        .EXE_W    (EXE_W)
    ) u_map (
        .is_flat_i   (cls_i[CB_FLAT]),
        .is_local_i  (cls_i[CB_LMEM]),
        .is_global_i (cls_i[CB_GMEM]),
        .is_scalar_i (is_scalar),
        .is_exec_i   (is_exec),
        .idx_o       (map_idx)
    );

    // Walk the not-ready conditions from highest to lowest priority.
    always_comb begin
        reason     = RSN_READY;
        bar_hit    = 1'b0;
        zero_set_o = 1'b0;
        bad_cls_o  = 1'b0;
        if (state_i == ST_WAITCNT && !wait_met_i) begin
            reason = RSN_WAIT_CNT;
        end else if (state_i == ST_BARRIER && !bar_done_i[bar_sel_i]) begin
            reason = RSN_BAR_WAIT;
        end else begin
            bar_hit = (state_i == ST_BARRIER);
            if (halted) begin
                reason = RSN_WF_STOP;
            end else if (!ib_has_i) begin
                reason = RSN_IB_EMPTY;
            end else if (!known) begin
                bad_cls_o = 1'b1;
                reason    = RSN_WF_STOP;
            end else if (!is_scalar && !vreg_ok_i) begin
                reason = RSN_VREG;
            end else if (!sreg_ok_i) begin
                reason = RSN_SREG;
            end else if (cls_i[CB_ENDPGM]) begin
                if (!ib_oldest_i) begin
                    reason = RSN_WAIT_CNT;
                end else begin
                    zero_set_o = 1'b1;
                    if (!wait_drained_i) reason = RSN_WAIT_CNT;
                end
            end
        end
    end

    // Drive the flattened results; the index is meaningful only when ready.
    always_comb begin
        reason_o  = reason;
        exe_idx_o = (reason == RSN_READY) ? map_idx : '0;
        bar_clr_o = '0;
        if (bar_hit) bar_clr_o[bar_sel_i] = 1'b1;
    end

endmodule

// File: rtl/wfrdy_stall_bank.sv
// One saturating counter per reason code. Each counter adds the number of
// slots that reported its reason in the cycle. Assumes CNT_W > $clog2(NW+1).
module wfrdy_stall_bank
    import wfrdy_pkg::*;
#(
    parameter int NW    = 4,
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NW*RSN_W-1:0]      reason_i,
    output logic [NUM_RSN*CNT_W-1:0] cnt_o
);

    localparam int INC_W = $clog2(NW + 1);

    logic live_q;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    for (genvar r = 0; r < NUM_RSN; r++) begin : g_rsn
        logic [INC_W-1:0] inc;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W:0]   sum;

        // Count the slots that ended with this reason.
        always_comb begin
            inc = '0;
            for (int s = 0; s < NW; s++) begin
                if (reason_i[s*RSN_W +: RSN_W] == RSN_W'(r)) inc = inc + INC_W'(1);
            end
        end

        assign sum = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};

        // Accumulate with saturation at all ones.
        always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (sum[CNT_W]) cnt_q <= '1;
            else               cnt_q <= sum[CNT_W-1:0];
        end

        assign cnt_o[r*CNT_W +: CNT_W] = cnt_q;

        p_no_decrease_r11: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> cnt_q >= $past(cnt_q));
    end

    for (genvar s = 0; s < NW; s++) begin : g_legal
        p_no_illegal_r12: assert property (@(posedge clk) disable iff (!rst_n)
            reason_i[s*RSN_W +: RSN_W] != RSN_ILLEGAL);
    end

endmodule

// File: rtl/wave_issue_gate.sv
// Wavefront issue readiness checker, top level.
// Evaluates every slot of every SIMD in parallel, registers the per-slot
// ready flag, reason and resource index, merges the barrier clear pulses
// and keeps the per-reason stall counters. Slot s = simd*WF_PER_SIMD + wf.
// Assumes NUM_BAR >= 2 and every bar_sel_i value below NUM_BAR.
module wave_issue_gate
    import wfrdy_pkg::*;
#(
    parameter int NUM_SIMD    = 2,
    parameter int WF_PER_SIMD = 2,
    parameter int NUM_BAR     = 4,
    parameter int CNT_W       = 32,
    localparam int NW         = NUM_SIMD * WF_PER_SIMD,
    localparam int BAR_W      = $clog2(NUM_BAR),
    localparam int NUM_EXE    = NUM_SIMD + 4,
    localparam int EXE_W      = $clog2(NUM_EXE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NW*3-1:0]          wf_state_i,
    input  logic [NW-1:0]            wait_met_i,
    input  logic [NW-1:0]            wait_drained_i,
    input  logic [NW*BAR_W-1:0]      bar_sel_i,
    input  logic [NUM_BAR-1:0]       bar_done_i,
    input  logic [NW-1:0]            ib_has_i,
    input  logic [NW-1:0]            ib_oldest_i,
    input  logic [NW*CLS_W-1:0]      inst_class_i,
    input  logic [NW-1:0]            vreg_ok_i,
    input  logic [NW-1:0]            sreg_ok_i,
    output logic [NW-1:0]            issue_rdy_o,
    output logic [NW*RSN_W-1:0]      reason_o,
    output logic [NW*EXE_W-1:0]      exe_idx_o,
    output logic [NW-1:0]            zero_wait_set_o,
    output logic [NUM_BAR-1:0]       bar_clear_o,
    output logic                     class_err_o,
    output logic [NUM_RSN*CNT_W-1:0] stall_cnt_o
);

    logic [NW*RSN_W-1:0]      reason_c;
    logic [NW*EXE_W-1:0]      idx_c;
    logic [NW-1:0]            zset_c;
    logic [NW-1:0]            bad_c;
    logic [NW*NUM_BAR-1:0]    bclr_c;
    logic [NUM_BAR-1:0]       bclr_any;
    logic                     live_q;

    for (genvar gs = 0; gs < NUM_SIMD; gs++) begin : g_simd
        for (genvar gw = 0; gw < WF_PER_SIMD; gw++) begin : g_wf
            localparam int S = gs * WF_PER_SIMD + gw;
            wfrdy_slot_eval #(
                .NUM_SIMD (NUM_SIMD),
                .SIMD_ID  (gs),
                .NUM_BAR  (NUM_BAR),
                .BAR_W    (BAR_W),
                .EXE_W    (EXE_W)
            ) u_eval (
                .state_i        (wf_state_i[S*3 +: 3]),
                .wait_met_i     (wait_met_i[S]),
                .wait_drained_i (wait_drained_i[S]),
                .bar_sel_i      (bar_sel_i[S*BAR_W +: BAR_W]),
                .bar_done_i     (bar_done_i),
                .ib_has_i       (ib_has_i[S]),
                .ib_oldest_i    (ib_oldest_i[S]),
                .cls_i          (inst_class_i[S*CLS_W +: CLS_W]),
                .vreg_ok_i      (vreg_ok_i[S]),
                .sreg_ok_i      (sreg_ok_i[S]),
                .reason_o       (reason_c[S*RSN_W +: RSN_W]),
                .exe_idx_o      (idx_c[S*EXE_W +: EXE_W]),
                .zero_set_o     (zset_c[S]),
                .bar_clr_o      (bclr_c[S*NUM_BAR +: NUM_BAR]),
                .bad_cls_o      (bad_c[S])
            );
        end
    end

    // Merge the per-slot barrier clear requests into one pulse per id.
    always_comb begin
        bclr_any = '0;
        for (int s = 0; s < NW; s++) bclr_any = bclr_any | bclr_c[s*NUM_BAR +: NUM_BAR];
    end

    // Register the per-slot results and the sticky class error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_rdy_o     <= '0;
            reason_o        <= '0;
            exe_idx_o       <= '0;
            zero_wait_set_o <= '0;
            bar_clear_o     <= '0;
            class_err_o     <= 1'b0;
            live_q          <= 1'b0;
        end else begin
            for (int s = 0; s < NW; s++) begin
                issue_rdy_o[s] <= (reason_c[s*RSN_W +: RSN_W] == RSN_READY);
            end
            reason_o        <= reason_c;
            exe_idx_o       <= idx_c;
            zero_wait_set_o <= zset_c;
            bar_clear_o     <= bclr_any;
            class_err_o     <= class_err_o | (|bad_c);
            live_q          <= 1'b1;
        end
    end

    wfrdy_stall_bank #(
        .NW    (NW),
        .CNT_W (CNT_W)
    ) u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .reason_i (reason_c),
        .cnt_o    (stall_cnt_o)
    );

    for (genvar s = 0; s < NW; s++) begin : g_chk
        p_waitcnt_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && $past(wf_state_i[s*3 +: 3] == ST_WAITCNT && !wait_met_i[s])
            |-> reason_o[s*RSN_W +: RSN_W] == RSN_WAIT_CNT);
        p_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && $past(wf_state_i[s*3 +: 3] == ST_STOPPED ||
                            wf_state_i[s*3 +: 3] == ST_STALLED ||
                            wf_state_i[s*3 +: 3] == ST_RETURNING)
            |-> reason_o[s*RSN_W +: RSN_W] == RSN_WF_STOP);
        p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && $past(wf_state_i[s*3 +: 3] == ST_RUN && !ib_has_i[s])
            |-> reason_o[s*RSN_W +: RSN_W] == RSN_IB_EMPTY);
        p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !issue_rdy_o[s] |-> exe_idx_o[s*EXE_W +: EXE_W] == '0);
    end

    for (genvar b = 0; b < NUM_BAR; b++) begin : g_bchk
        p_clear_needs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && bar_clear_o[b] |-> $past(bar_done_i[b]));
    end

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        class_err_o |=> class_err_o);

endmodule

// File: tb/tb_wave_issue_gate.sv
// Sweep bench for wave_issue_gate: 2 SIMDs x 2 slots, 4 barriers, 8-bit
// counters. Expected values come from a model written from the requirements.
`timescale 1ns/1ps
module tb_wave_issue_gate;

    localparam int NS = 2, WPS = 2, NB = 4, CW = 8;
    localparam int NW = NS * WPS;
    localparam int BW = 2, EW = 3, CLW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]    st     [NW];
    logic          wmet   [NW];
    logic          wdrn   [NW];
    logic [BW-1:0] bsel   [NW];
    logic          ibh    [NW];
    logic          ibo    [NW];
    logic [CLW-1:0] cls   [NW];
    logic          vok    [NW];
    logic          sok    [NW];
    logic [NB-1:0] bdone;

    logic [NW*3-1:0]   wf_state;
    logic [NW-1:0]     wait_met, wait_drained, ib_has, ib_oldest, vreg_ok, sreg_ok;
    logic [NW*BW-1:0]  bar_sel;
    logic [NW*CLW-1:0] inst_class;

    logic [NW-1:0]     issue_rdy;
    logic [NW*3-1:0]   reason;
    logic [NW*EW-1:0]  exe_idx;
    logic [NW-1:0]     zero_set;
    logic [NB-1:0]     bar_clear;
    logic              class_err;
    logic [8*CW-1:0]   stall_cnt;

    always_comb begin
        for (int s = 0; s < NW; s++) begin
            wf_state[s*3 +: 3]       = st[s];
            wait_met[s]              = wmet[s];
            wait_drained[s]          = wdrn[s];
            bar_sel[s*BW +: BW]      = bsel[s];
            ib_has[s]                = ibh[s];
            ib_oldest[s]             = ibo[s];
            inst_class[s*CLW +: CLW] = cls[s];
            vreg_ok[s]               = vok[s];
            sreg_ok[s]               = sok[s];
        end
    end

    wave_issue_gate #(.NUM_SIMD(NS), .WF_PER_SIMD(WPS), .NUM_BAR(NB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wf_state_i(wf_state), .wait_met_i(wait_met),
        .wait_drained_i(wait_drained), .bar_sel_i(bar_sel), .bar_done_i(bdone),
        .ib_has_i(ib_has), .ib_oldest_i(ib_oldest), .inst_class_i(inst_class),
        .vreg_ok_i(vreg_ok), .sreg_ok_i(sreg_ok), .issue_rdy_o(issue_rdy),
        .reason_o(reason), .exe_idx_o(exe_idx), .zero_wait_set_o(zero_set),
        .bar_clear_o(bar_clear), .class_err_o(class_err), .stall_cnt_o(stall_cnt)
    );

    int checks = 0;
    int errors = 0;
    int exp_cnt [8];
    logic exp_err = 1'b0;
    int cyc = 0;
    bit done = 0;

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Class word for a kind index.
    function automatic logic [CLW-1:0] kind_word(input int k);
        case (k)
            0:  return 15'(1 << 0);
            1:  return 15'((1 << 0) | (1 << 11));
            2:  return 15'((1 << 1) | (1 << 11));
            3:  return 15'((1 << 6) | (1 << 13));
            4:  return 15'((1 << 6) | (1 << 13) | (1 << 11));
            5:  return 15'((1 << 7) | (1 << 12));
            6:  return 15'((1 << 8) | (1 << 10));
            7:  return 15'((1 << 4) | (1 << 11));
            8:  return 15'((1 << 5) | (1 << 11));
            9:  return 15'((1 << 2) | (1 << 3));
            10: return 15'((1 << 6) | (1 << 14) | (1 << 11));
            11: return 15'(1 << 9);
            default: return 15'(1 << 11);
        endcase
    endfunction

    // Requirement model for one slot.
    function automatic void model(input int s, output int rsn, output int idx,
                                  output bit zs, output bit bh, output bit bad);
        logic [CLW-1:0] c = cls[s];
        bit sc = c[11];
        int m;
        rsn = 7; idx = 0; zs = 0; bh = 0; bad = 0;
        if (st[s] == 3'd4 && !wmet[s]) begin rsn = 3; return; end
        if (st[s] == 3'd5 && !bdone[bsel[s]]) begin rsn = 4; return; end
        bh = (st[s] == 3'd5);
        if (st[s] >= 3'd1 && st[s] <= 3'd3) rsn = 1;
        else if (!ibh[s]) rsn = 2;
        else if (c[10:0] == 11'd0) begin rsn = 1; bad = 1; end
        else if (!sc && !vok[s]) rsn = 5;
        else if (!sok[s]) rsn = 6;
        else if (c[4]) begin
            if (!ibo[s]) rsn = 3;
            else begin zs = 1; if (!wdrn[s]) rsn = 3; end
        end
        if (rsn == 7) begin
            if (c[10]) m = NS + 1;
            else if (c[12]) m = NS + 2;
            else if (c[13]) m = sc ? NS + 3 : NS + 1;
            else if (c[0] | c[1] | c[3] | c[4] | c[2] | c[5] | (c[14] & c[6]))
                m = sc ? NS : s / WPS;
            else m = NS + 4;
            idx = m;
        end
    endfunction

    function automatic string tag_of(input int rsn, input int s);
        case (rsn)
            1: return (cls[s][10:0] == 0 && ibh[s] && st[s] != 1 && st[s] != 2 && st[s] != 3) ? "R9" : "R4";
            2: return "R5";
            3: return cls[s][4] ? "R7" : "R1";
            4: return "R2";
            5, 6: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Drive the current stimulus, predict, and check one clock later.
    task automatic step(input string force_tag);
        int rsn [NW]; int idx [NW]; bit zs [NW]; bit bh; bit bad; logic [NB-1:0] eclr;
        string t;
        int n [8];
        eclr = '0;
        for (int r = 0; r < 8; r++) n[r] = 0;
        for (int s = 0; s < NW; s++) begin
            model(s, rsn[s], idx[s], zs[s], bh, bad);
            if (bh) eclr[bsel[s]] = 1'b1;
            if (bad) exp_err = 1'b1;
            n[rsn[s]]++;
        end
        for (int r = 0; r < 8; r++) exp_cnt[r] = (exp_cnt[r] + n[r] > 255) ? 255 : exp_cnt[r] + n[r];
        @(posedge clk);
        #1;
        for (int s = 0; s < NW; s++) begin
            t = (force_tag != "") ? force_tag : tag_of(rsn[s], s);
            check(t, $sformatf("slot%0d reason", s), int'(reason[s*3 +: 3]), rsn[s]);
            check("R8", $sformatf("slot%0d ready", s), int'(issue_rdy[s]), int'(rsn[s] == 7));
            check("R8", $sformatf("slot%0d index", s), int'(exe_idx[s*EW +: EW]), idx[s]);
            check("R7", $sformatf("slot%0d zero-wait", s), int'(zero_set[s]), int'(zs[s]));
            check("R12", $sformatf("slot%0d legal", s), int'(reason[s*3 +: 3] == 3'd0), 0);
        end
        check("R2", "barrier clear", int'(bar_clear), int'(eclr));
        check("R9", "class error", int'(class_err), int'(exp_err));
        for (int r = 0; r < 8; r++)
            check("R11", $sformatf("counter%0d", r), int'(stall_cnt[r*CW +: CW]), exp_cnt[r]);
    endtask

    task automatic randomize_slots(input int kinds);
        for (int s = 0; s < NW; s++) begin
            int r = int'($urandom % 10);
            st[s]   = (r < 6) ? 3'(r) : 3'(r - 2);
            wmet[s] = 1'($urandom % 2);
            wdrn[s] = 1'($urandom % 2);
            bsel[s] = BW'($urandom % NB);
            ibh[s]  = ($urandom % 8) != 0;
            ibo[s]  = 1'($urandom % 2);
            cls[s]  = kind_word(int'($urandom % kinds));
            vok[s]  = ($urandom % 4) != 0;
            sok[s]  = ($urandom % 4) != 0;
        end
        bdone = NB'($urandom);
    endtask

    task automatic set_idle();
        for (int s = 0; s < NW; s++) begin
            st[s] = 3'd0; wmet[s] = 1; wdrn[s] = 1; bsel[s] = '0; ibh[s] = 1;
            ibo[s] = 1; cls[s] = kind_word(0); vok[s] = 1; sok[s] = 1;
        end
        bdone = '0;
    endtask

    // Watchdog: a hung run is a failure and still ends with the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) exp_cnt[r] = 0;
        set_idle();
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset ready", int'(issue_rdy), 0);
        check("R10", "reset reason", int'(reason), 0);
        check("R10", "reset counters", int'(stall_cnt != '0), 0);
        check("R10", "reset clear/err", int'({bar_clear, class_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: barrier with empty buffer, open then completed
        set_idle();
        st[0] = 3'd5; ibh[0] = 0; bsel[0] = 2'd1; st[2] = 3'd5; bsel[2] = 2'd1;
        step("R3");
        @(negedge clk); bdone = 4'b0010;
        step("R3");
        // R1: wait-count state outranks everything else
        @(negedge clk); set_idle(); st[1] = 3'd4; wmet[1] = 0; ibh[1] = 0; cls[1] = kind_word(12);
        step("R1");
        // R7: end of program, not oldest / oldest undrained / drained
        @(negedge clk); set_idle(); cls[3] = kind_word(7); ibo[3] = 0;
        step("R7");
        @(negedge clk); ibo[3] = 1; wdrn[3] = 0;
        step("R7");
        @(negedge clk); wdrn[3] = 1;
        step("R7");
        // R6: vector check before scalar check
        @(negedge clk); set_idle(); vok[2] = 0; sok[2] = 0; sok[1] = 0; cls[0] = kind_word(1); vok[0] = 0;
        step("R6");

        for (int i = 0; i < 400; i++) begin
            @(negedge clk); randomize_slots(12); step("");
        end
        check("R9", "no error before unknown class", int'(class_err), 0);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); randomize_slots(13); step("");
        end
        check("R11", "counter saturated", int'(stall_cnt[7*CW +: CW]), 255);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule